// File: doc/BRIEF.md
# RTC Once-Per-Second Update Sequencer

This block paces the once-per-second timekeeping update of a real-time clock. A divided timebase supplies a `tick` strobe. A sub-second counter counts these ticks and closes a window of `UPD_TICKS` ticks at the end of every second. When that window opens, the block issues a single-cycle `advance` pulse, which stands in for the calendar arithmetic. When the window closes, the block sets an update-ended flag and, if software allows it, an interrupt request.

A status bit `uip` goes high `LEAD_TICKS` ticks before the window opens and stays high until the window closes. Software that sees `uip` low therefore has at least that lead time to read the clock bytes safely. Reading the status register, marked by `statusRd`, clears both the flag and the request.

A 3-bit control field gates the whole chain. Only the value 010 runs the divider. Values 110 and 111 keep the oscillator running with the divider held. Every other value stops the oscillator.

Top module: `rtc_update_seq`

## Requirements
- R1: With `oscCtrl` = 3'b010, both `oscOn` and `divRun` are 1.
- R2: With `oscCtrl` = 3'b110 or 3'b111, `oscOn` is 1 and `divRun` is 0. No `advance`, no `uip` and no new flag or request occur.
- R3: With any other `oscCtrl` value, both `oscOn` and `divRun` are 0.
- R4: While the divider runs, the sub-second count advances on each clock that has `tick` high and wraps after `TICKS_PER_SEC` ticks. On the clock after the wrapping tick, `updFlag` is 1.
- R5: `advance` is a one-cycle pulse. It appears on the clock after the tick that leaves `UPD_TICKS` ticks before the wrap, which marks the start of the update.
- R6: `uip` is 1 exactly while the sub-second count is at least `TICKS_PER_SEC-UPD_TICKS-LEAD_TICKS`. It therefore rises `LEAD_TICKS` ticks before the update starts and falls when the update ends.
- R7: At the end of an update, `irq` is set only if `updIntEn` is 1 and `updInhibit` is 0 on that clock. Otherwise `irq` keeps its value.
- R8: A clock with `statusRd` high clears `updFlag` and `irq`. If an update ends on the same clock, the set wins.
- R9: When the divider stops, the sub-second count returns to 0. After the divider restarts, the first update ends on the `TICKS_PER_SEC`-th tick.
- R10: After reset, `updFlag`, `irq`, `advance` and `uip` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Divided timebase strobe, one clock wide |
| oscCtrl | input | 3 | Oscillator/divider control field |
| updIntEn | input | 1 | Update interrupt enable |
| updInhibit | input | 1 | Update transfer inhibit |
| statusRd | input | 1 | Status register read strobe |
| oscOn | output | 1 | Oscillator running |
| divRun | output | 1 | Divider running |
| uip | output | 1 | Update in progress or imminent |
| advance | output | 1 | Calendar advance pulse |
| updFlag | output | 1 | Update-ended flag |
| irq | output | 1 | Update interrupt request |

## Verification
`oscOn` and `divRun` follow `oscCtrl` within the same cycle. The sub-second count is registered, so `uip` changes one clock after the tick that moves the count across the lead threshold. `advance`, `updFlag` and `irq` are registered from the sampled tick, read and enable inputs, so each is due on the clock after the triggering edge. The bench drives inputs on the falling edge, advances its own model at the rising edge, and compares every output 1 ns after that rising edge. In addition, the restart case counts ticks from re-enable until `updFlag` appears.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;
  // Strobes passed from the sequencing control to the flag datapath.
  typedef struct packed {
    logic updStart;  // tick that opens the update window
    logic updEnd;    // tick that closes the update window (count wrap)
  } updStrobe_t;

  localparam logic [2:0] RUN_PATTERN = 3'b010;
endpackage

// File: rtl/rtc_osc_decode.sv
module rtc_osc_decode
  import rtc_upd_pkg::*;
(
  input  logic [2:0] ctrlField,
  output logic       oscOn,
  output logic       divRun
);
  always_comb begin
    divRun = (ctrlField == RUN_PATTERN);
    oscOn  = divRun || (ctrlField[2:1] == 2'b11);
  end
endmodule

// File: rtl/rtc_upd_ctrl.sv
module rtc_upd_ctrl
  import rtc_upd_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1024,
  parameter int LEAD_TICKS    = 8,
  parameter int UPD_TICKS     = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       divRun,
  input  logic       tick,
  output updStrobe_t strb,
  output logic       uip
);
  localparam int CNT_W = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(TICKS_PER_SEC - 1);
  localparam logic [CNT_W-1:0] PRE_START = CNT_W'(TICKS_PER_SEC - UPD_TICKS - 1);
  localparam logic [CNT_W-1:0] UIP_START = CNT_W'(TICKS_PER_SEC - UPD_TICKS - LEAD_TICKS);

  logic [CNT_W-1:0] subCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !divRun) begin
      subCnt <= '0;
    end else if (tick) begin
      subCnt <= (subCnt == LAST_CNT) ? '0 : subCnt + 1'b1;
    end
  end

  always_comb begin
    strb.updStart = divRun && tick && (subCnt == PRE_START);
    strb.updEnd   = divRun && tick && (subCnt == LAST_CNT);
    uip           = (subCnt >= UIP_START);
  end
endmodule

// File: rtl/rtc_upd_flags.sv
module rtc_upd_flags
  import rtc_upd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  updStrobe_t strb,
  input  logic       updIntEn,
  input  logic       updInhibit,
  input  logic       statusRd,
  output logic       updFlag,
  output logic       irq,
  output logic       advance
);
  logic irqSet;

  always_comb irqSet = strb.updEnd && updIntEn && !updInhibit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      updFlag <= 1'b0;
      irq     <= 1'b0;
      advance <= 1'b0;
    end else begin
      advance <= strb.updStart;
      updFlag <= strb.updEnd || (updFlag && !statusRd);
      irq     <= irqSet || (irq && !statusRd);
    end
  end
endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq
  import rtc_upd_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1024,
  parameter int LEAD_TICKS    = 8,
  parameter int UPD_TICKS     = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [2:0] oscCtrl,
  input  logic       updIntEn,
  input  logic       updInhibit,
  input  logic       statusRd,
  output logic       oscOn,
  output logic       divRun,
  output logic       uip,
  output logic       advance,
  output logic       updFlag,
  output logic       irq
);
  updStrobe_t strb;

  rtc_osc_decode uDecode (
    .ctrlField(oscCtrl),
    .oscOn    (oscOn),
    .divRun   (divRun)
  );

  rtc_upd_ctrl #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .LEAD_TICKS   (LEAD_TICKS),
    .UPD_TICKS    (UPD_TICKS)
  ) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .divRun(divRun),
    .tick  (tick),
    .strb  (strb),
    .uip   (uip)
  );

  rtc_upd_flags uFlags (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .updIntEn  (updIntEn),
    .updInhibit(updInhibit),
    .statusRd  (statusRd),
    .updFlag   (updFlag),
    .irq       (irq),
    .advance   (advance)
  );
endmodule

// File: rtl/rtc_update_seq_chk.sv
module rtc_update_seq_chk (
  input logic clk,
  input logic rstN,
  input logic updIntEn,
  input logic updInhibit,
  input logic statusRd,
  input logic divRun,
  input logic oscOn,
  input logic uip,
  input logic advance,
  input logic updFlag,
  input logic irq
);
  // R1
  run_needs_osc_chk: assert property (@(posedge clk) disable iff (!rstN)
    divRun |-> oscOn);

  // R2
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !divRun |=> !uip && !advance);

  // R4
  flag_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(updFlag) |-> $past(uip) && !uip);

  // R5
  adv_in_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    advance |-> uip);

  // R5
  adv_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    advance |=> !advance);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(updIntEn && !updInhibit));

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !uip) |=> !updFlag && !irq);
endmodule

bind rtc_update_seq rtc_update_seq_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .updIntEn  (updIntEn),
  .updInhibit(updInhibit),
  .statusRd  (statusRd),
  .divRun    (divRun),
  .oscOn     (oscOn),
  .uip       (uip),
  .advance   (advance),
  .updFlag   (updFlag),
  .irq       (irq)
);

// File: tb/rtc_update_seq_test.sv
module rtc_update_seq_test;
  localparam int PER  = 16;
  localparam int LEAD = 3;
  localparam int UPD  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic [2:0] oscCtrl = 3'b000;
  logic updIntEn = 1'b0;
  logic updInhibit = 1'b0;
  logic statusRd = 1'b0;
  logic oscOn, divRun, uip, advance, updFlag, irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // model state
  int  mCnt = 0;
  logic mUf = 1'b0, mIrq = 1'b0, mAdv = 1'b0;

  always #10 clk = ~clk;

  rtc_update_seq #(.TICKS_PER_SEC(PER), .LEAD_TICKS(LEAD), .UPD_TICKS(UPD)) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .oscCtrl(oscCtrl),
    .updIntEn(updIntEn), .updInhibit(updInhibit), .statusRd(statusRd),
    .oscOn(oscOn), .divRun(divRun), .uip(uip), .advance(advance),
    .updFlag(updFlag), .irq(irq)
  );

  function automatic logic expOsc(logic [2:0] c);
    return (c == 3'b010) || (c[2:1] == 2'b11);
  endfunction

  function automatic logic expRun(logic [2:0] c);
    return c == 3'b010;
  endfunction

  function automatic string oscReq(logic [2:0] c);
    if (c == 3'b010) return "R1";
    if (c[2:1] == 2'b11) return "R2";
    return "R3";
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk(oscReq(oscCtrl), "oscOn", oscOn, expOsc(oscCtrl));
    chk(oscReq(oscCtrl), "divRun", divRun, expRun(oscCtrl));
    chk(expRun(oscCtrl) ? "R6" : "R2", "uip", uip, logic'(mCnt >= PER - UPD - LEAD));
    chk("R4", "updFlag", updFlag, mUf);
    chk("R7", "irq", irq, mIrq);
    chk("R5", "advance", advance, mAdv);
  endtask

  task automatic step(logic t, logic [2:0] c, logic ie, logic inh, logic rd);
    logic run, endEv;
    @(negedge clk);
    tick = t; oscCtrl = c; updIntEn = ie; updInhibit = inh; statusRd = rd;
    @(posedge clk);
    run   = expRun(c);
    endEv = run && t && (mCnt == PER - 1);
    mAdv  = run && t && (mCnt == PER - UPD - 1);
    mUf   = endEv || (mUf && !rd);
    mIrq  = (endEv && ie && !inh) || (mIrq && !rd);
    if (!run) mCnt = 0;
    else if (t) mCnt = (mCnt == PER - 1) ? 0 : mCnt + 1;
    #1;
    compareAll();
  endtask

  initial begin : watchdog
    #(20 * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int n;
    int seedDummy;
    logic [2:0] c;
    logic ie, inh;
    seedDummy = $urandom(32'd4242);

    // R10 reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "uip", uip, 1'b0);
    chk("R10", "updFlag", updFlag, 1'b0);
    chk("R10", "irq", irq, 1'b0);
    chk("R10", "advance", advance, 1'b0);
    @(negedge clk);
    rstN = 1'b1;

    // R4 R5 R6 R7: steady running, interrupts enabled
    for (int i = 0; i < 3 * PER; i++) step(1'b1, 3'b010, 1'b1, 1'b0, 1'b0);
    // R8: read clears
    step(1'b0, 3'b010, 1'b1, 1'b0, 1'b1);
    // R7: inhibited - flag sets, irq does not
    for (int i = 0; i < 2 * PER; i++) step(1'b1, 3'b010, 1'b1, 1'b1, i == 5);
    // R8: read on the same clock as the update end (set wins)
    while (mCnt != PER - 1) step(1'b1, 3'b010, 1'b1, 1'b0, 1'b0);
    step(1'b1, 3'b010, 1'b1, 1'b0, 1'b1);
    chk("R8", "set wins flag", updFlag, 1'b1);
    chk("R8", "set wins irq", irq, 1'b1);

    // R2 R3: all stopped codes, with ticks flowing
    for (int v = 0; v < 8; v++) begin
      if (v != 2) for (int i = 0; i < PER + 4; i++) step(1'b1, 3'(v), 1'b1, 1'b0, i == 0);
    end

    // R9: stop mid-second, restart, count ticks to the first update
    for (int i = 0; i < PER / 2; i++) step(1'b1, 3'b010, 1'b0, 1'b0, 1'b0);
    step(1'b1, 3'b110, 1'b0, 1'b0, 1'b1);
    step(1'b1, 3'b000, 1'b0, 1'b0, 1'b0);
    n = 0;
    do begin
      step(1'b1, 3'b010, 1'b0, 1'b0, 1'b0);
      n++;
    end while (!updFlag && n < 4 * PER);
    checks++;
    if (n != PER) begin
      failures++;
      $display("FAIL R9 ticks to first update actual=%0d expected=%0d", n, PER);
    end

    // random phase
    c = 3'b010; ie = 1'b1; inh = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 99) == 0) c = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 19) == 0) c = 3'b010;
      if ($urandom_range(0, 49) == 0) ie = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 49) == 0) inh = 1'($urandom_range(0, 1));
      step(1'($urandom_range(0, 1)), c, ie, inh, $urandom_range(0, 9) == 0);
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule